// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counters, each made of a low and a high 8-bit count register. A shared configuration register gives each timer a 4-bit setting. The setting picks one of four count structures, picks between counting machine-cycle ticks and counting falling edges on an external pin, and can make counting depend on an external gate pin. A control register holds a run bit and an overflow flag for each timer. The flags also drive the block's outputs toward an interrupt controller.

Software reaches all six registers through a simple register bus. Writes take effect on the next clock edge, and reads are combinational. When the interrupt controller vectors to a timer's handler, it pulses that timer's acknowledge input to clear the flag. Timer 0 has a split setting in which its two halves become independent 8-bit counters. In that setting, timer 0's high half takes over timer 1's run bit and flag.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00 and both flag outputs are low.
- R2: A write with wr_en_i high lands on the next clock edge at the register chosen by addr_i: 0 config, 1 control, 2 and 3 timer 0 low and high, 4 and 5 timer 1 low and high. A count-register write takes priority over counting in the same cycle. The config register holds timer 1 in bits 7:4 and timer 0 in bits 3:0, each nibble being {gate, pin-count, mode[1:0]}.
- R3: The control register holds {flag1, run1, flag0, run0} in bits 7:4, and bits 3:0 read as zero. A timer whose run bit is 0 does not count.
- R4: When a timer's gate bit is 1, it counts only in cycles where its gate pin is high.
- R5: With pin-count = 1, a timer counts on a tick where its count pin was 1 at the previous tick and is 0 at this one. With pin-count = 0, it counts every tick.
- R6: In mode 00, low bits 4:0 form a divide-by-32 prescaler and the high register advances when the prescaler wraps. The 13-bit value wraps from all ones to zero and sets the flag, and low bits 7:5 are left unchanged.
- R7: In mode 01, {high, low} is a 16-bit counter that wraps from 0xFFFF to 0x0000 and sets the flag.
- R8: In mode 10, the low register counts. On overflow from 0xFF it reloads from the high register and sets the flag, and the high register is left unchanged.
- R9: Timer 0 in mode 11 has two halves. The low half counts under timer 0's run, gate and pin-count settings and sets flag 0. The high half counts every tick while run1 is 1 and sets flag 1. Timer 1's own overflow then leaves flag 1 alone.
- R10: Timer 1 in mode 11 holds its count.
- R11: Overflow sets a flag. A pulse on ack_i[n] clears flag n. A control write sets flags to the written bits. A hardware set in the same cycle wins over both.
- R12: ovf_o[n] equals flag n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per machine cycle |
| cnt_pin_i | input | 2 | External count pins, bit n for timer n |
| gate_pin_i | input | 2 | External gate pins, bit n for timer n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ack_i | input | 2 | Flag clear from interrupt vectoring |
| ovf_o | output | 2 | Overflow flags |

## Verification
The embedded properties watch several rules on every cycle:
- a stopped timer holding its low register;
- the reload and carry paths;
- a frozen timer 1 in mode 11;
- flags being set and cleared;
- flag 1 being raised only by timer 0's high half in split mode.

The exact count sequences need the bench's step-by-step arithmetic models, which compare every step of each mode sweep. These sequences are the 13-bit prescale wrap, the 16-bit wrap, and the gated and edge-counted patterns. The bench also shows the set-beats-acknowledge race and the register readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'b00,
    MD_FULL16  = 2'b01,
    MD_RELOAD8 = 2'b10,
    MD_SPLIT   = 2'b11
  } tmr_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE  = 3'd0,
    A_CTRL  = 3'd1,
    A_T0_LO = 3'd2,
    A_T0_HI = 3'd3,
    A_T1_LO = 3'd4,
    A_T1_HI = 3'd5
  } tmr_addr_e;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  // pins are sampled once per machine cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= '0;
    else if (tick_i) prev_q <= pin_i;
  end

  assign fall_o = {N{tick_i}} & prev_q & ~pin_i;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit import tmr_pkg::*; #(
  parameter bit          SPLIT_OK = 1'b0,
  parameter int unsigned DW       = 8,
  parameter int unsigned PRE_W    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    cfg_i,      // {gate, pin_count, mode[1:0]}
  input  logic          run_i,
  input  logic          hi_run_i,   // split-mode run for the high half
  input  logic          tick_i,
  input  logic          evt_i,
  input  logic          gate_pin_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          ovf_o,
  output logic          ovf_hi_o
);
  localparam int unsigned CW = 2 * DW;

  tmr_mode_e     mode;
  logic          go, inc, hi_inc;
  logic [DW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [CW-1:0] full_n;
  logic          ovf_n, ovf_hi_n;

  assign mode   = tmr_mode_e'(cfg_i[1:0]);
  assign go     = run_i & (~cfg_i[3] | gate_pin_i);
  assign inc    = go & (cfg_i[2] ? evt_i : tick_i) & (SPLIT_OK | (mode != MD_SPLIT));
  assign hi_inc = (SPLIT_OK && mode == MD_SPLIT) ? (hi_run_i & tick_i) : 1'b0;
  assign full_n = {hi_q, lo_q} + 1'b1;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_n    = 1'b0;
    ovf_hi_n = 1'b0;
    if (inc) begin
      case (mode)
        MD_PRE13: begin
          lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          if (&lo_q[PRE_W-1:0]) begin
            hi_n  = hi_q + 1'b1;
            ovf_n = &hi_q;
          end
        end
        MD_FULL16: begin
          lo_n  = full_n[DW-1:0];
          hi_n  = full_n[CW-1:DW];
          ovf_n = &{hi_q, lo_q};
        end
        MD_RELOAD8: begin
          if (&lo_q) begin
            lo_n  = hi_q;
            ovf_n = 1'b1;
          end else begin
            lo_n = lo_q + 1'b1;
          end
        end
        MD_SPLIT: begin
          lo_n  = lo_q + 1'b1;
          ovf_n = &lo_q;
        end
      endcase
    end
    if (hi_inc) begin
      hi_n     = hi_q + 1'b1;
      ovf_hi_n = &hi_q;
    end
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign ovf_o    = ovf_n;
  assign ovf_hi_o = ovf_hi_n;

  p_stopped_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_lo_i) |=> $stable(lo_q));

  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_RELOAD8 && inc && (&lo_q) && !wr_lo_i) |=> (lo_q == $past(hi_q)));

  p_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_FULL16 && inc && (&lo_q) && !wr_hi_i) |=> (hi_q == $past(hi_q) + 1'b1));

  p_split_hi_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_SPLIT && !hi_run_i && !wr_hi_i) |=> $stable(hi_q));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
  parameter int unsigned DW    = 8,
  parameter int unsigned PRE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [1:0]        ack_i,
  output logic [1:0]        ovf_o
);
  localparam int unsigned NT = 2;

  logic [7:0]    mode_q;
  logic [NT-1:0] tr_q, tf_q, tf_set, ovf_p, ovf_hi_p, evt;
  logic [DW-1:0] cnt_lo [NT];
  logic [DW-1:0] cnt_hi [NT];
  logic          wr_mode, wr_ctrl, wr_t1, split0;

  assign wr_mode = wr_en_i && addr_i == A_MODE;
  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_t1   = wr_en_i && (addr_i == A_T1_LO || addr_i == A_T1_HI);
  assign split0  = mode_q[1:0] == MD_SPLIT;

  tmr_edge #(.N(NT)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pin_i  (cnt_pin_i),
    .fall_o (evt)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(int'(A_T0_LO) + 2 * i);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(int'(A_T0_HI) + 2 * i);

    tmr_unit #(.SPLIT_OK(i == 0), .DW(DW), .PRE_W(PRE_W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (mode_q[4*i +: 4]),
      .run_i      (tr_q[i]),
      .hi_run_i   (tr_q[1]),
      .tick_i     (tick_i),
      .evt_i      (evt[i]),
      .gate_pin_i (gate_pin_i[i]),
      .wr_lo_i    (wr_en_i && addr_i == LO_A),
      .wr_hi_i    (wr_en_i && addr_i == HI_A),
      .wdata_i    (wdata_i),
      .lo_o       (cnt_lo[i]),
      .hi_o       (cnt_hi[i]),
      .ovf_o      (ovf_p[i]),
      .ovf_hi_o   (ovf_hi_p[i])
    );
  end

  // in split mode timer 0's high half owns flag 1
  assign tf_set[0] = ovf_p[0];
  assign tf_set[1] = split0 ? ovf_hi_p[0] : (ovf_p[1] | ovf_hi_p[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      tr_q   <= '0;
      tf_q   <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata_i[7:0];
      if (wr_ctrl) tr_q   <= {wdata_i[6], wdata_i[4]};
      for (int n = 0; n < NT; n++) begin
        if (tf_set[n])    tf_q[n] <= 1'b1;
        else if (wr_ctrl) tf_q[n] <= wdata_i[5 + 2*n];
        else if (ack_i[n]) tf_q[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (tmr_addr_e'(addr_i))
      A_MODE:  rdata_o = DW'(mode_q);
      A_CTRL:  rdata_o = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], {(DW-4){1'b0}}};
      A_T0_LO: rdata_o = cnt_lo[0];
      A_T0_HI: rdata_o = cnt_hi[0];
      A_T1_LO: rdata_o = cnt_lo[1];
      A_T1_HI: rdata_o = cnt_hi[1];
      default: rdata_o = '0;
    endcase
  end

  assign ovf_o = tf_q;

  p_flag_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_set[0] |=> tf_q[0]);

  p_ack_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !tf_set[0] && !wr_ctrl) |=> !tf_q[0]);

  p_t1_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[5:4] == MD_SPLIT && !wr_t1) |=> $stable({cnt_hi[1], cnt_lo[1]}));

  p_split_flag1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split0 && !ovf_hi_p[0] && !wr_ctrl) |=> !$rose(tf_q[1]));
endmodule

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] cnt_pin_i = '0;
  logic [1:0] gate_pin_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] ack_i = '0;
  logic [1:0] ovf_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tmr_pair u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick_i = t;
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic rd16(input int t, output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'(3 + 2*t), h);
    rd(3'(2 + 2*t), l);
    v = {h, l};
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v, v1;
    int p, h, l, f, f1, prev;
    int lo0, hi0;
    logic [15:0] pat;
    logic [19:0] cpat;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 0);
    end
    chk("R1 flags", ovf_o, 0);

    // R2 register access, R3 control layout, R12
    wr(0, 8'hA5); rd(0, d); chk("R2 config", d, 8'hA5);
    wr(2, 8'h3C); rd(2, d); chk("R2 t0 lo", d, 8'h3C);
    wr(3, 8'hC3); rd(3, d); chk("R2 t0 hi", d, 8'hC3);
    wr(4, 8'h5A); rd(4, d); chk("R2 t1 lo", d, 8'h5A);
    wr(5, 8'h96); rd(5, d); chk("R2 t1 hi", d, 8'h96);
    wr(1, 8'hFF); rd(1, d); chk("R3 ctrl low nibble zero", d, 8'hF0);
    chk("R12 flags follow ctrl", ovf_o, 2'b11);
    wr(1, 8'h00); rd(1, d); chk("R11 software clear", d, 0);
    chk("R12 flags clear", ovf_o, 0);

    // R7 16-bit timer with irregular ticks, R3 stop
    wr(0, 8'h01); wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h10);
    v = 16'hFFF0; f = 0;
    for (int k = 0; k < 24; k++) begin
      logic t;
      t = (k % 3) != 2;
      cyc(t);
      if (t) begin v = v + 1'b1; if (v == 0) f = 1; end
      rd16(0, v1);
      chk("R7 16-bit count", v1, v);
      chk("R7 flag0", ovf_o[0], f);
    end
    wr(1, 8'h20);
    for (int k = 0; k < 5; k++) cyc(1'b1);
    rd16(0, v1); chk("R3 stopped hold", v1, v);
    chk("R11 flag kept by write", ovf_o[0], 1);
    ack_i[0] = 1'b1; cyc(1'b0); ack_i[0] = 1'b0;
    chk("R11 ack clears", ovf_o[0], 0);

    // R4 gated counting
    wr(0, 8'h09); wr(2, 0); wr(3, 0); wr(1, 8'h10);
    pat = 16'hB4D3; v = 0;
    for (int k = 0; k < 16; k++) begin
      gate_pin_i[0] = pat[k];
      cyc(1'b1);
      if (pat[k]) v = v + 1'b1;
      rd16(0, v1);
      chk("R4 gated count", v1, v);
    end
    gate_pin_i = '0;
    wr(1, 8'h00);

    // R6 13-bit prescaled mode on timer 1
    wr(0, 8'h00); wr(4, 8'hFC); wr(5, 8'hFF); wr(1, 8'h40);
    p = 'h1C; h = 'hFF; f = 0;
    for (int k = 0; k < 40; k++) begin
      cyc(1'b1);
      p++;
      if (p == 32) begin p = 0; h = (h + 1) & 255; if (h == 0) f = 1; end
      rd(4, d); chk("R6 prescaler", d, 32'hE0 | p);
      rd(5, d); chk("R6 high count", d, h);
      chk("R6 flag1", ovf_o[1], f);
    end
    wr(1, 8'h00);

    // R8 auto-reload, R11 set beats ack
    wr(0, 8'h02); wr(3, 8'hF0); wr(2, 8'hFC); wr(1, 8'h10);
    l = 'hFC; f = 0;
    for (int k = 0; k < 40; k++) begin
      int ovf;
      ack_i[0] = f[0];
      cyc(1'b1);
      ack_i[0] = 1'b0;
      ovf = 0;
      l++;
      if (l == 256) begin l = 'hF0; ovf = 1; end
      f = ovf ? 1 : 0;
      rd(2, d); chk("R8 reload low", d, l);
      rd(3, d); chk("R8 high unchanged", d, 8'hF0);
      chk("R11 flag0 set/ack", ovf_o[0], f);
    end
    wr(1, 8'h00);

    // R5 falling-edge counting on timer 1
    wr(0, 8'h50); cnt_pin_i[1] = 1'b0; cyc(1'b1);
    wr(4, 0); wr(5, 0); wr(1, 8'h40);
    cpat = 20'hB5A6D; v = 0; prev = 0;
    for (int k = 0; k < 20; k++) begin
      logic t;
      t = (k % 5) != 4;
      cnt_pin_i[1] = cpat[k];
      cyc(t);
      if (t) begin
        if (prev == 1 && cpat[k] == 1'b0) v = v + 1'b1;
        prev = cpat[k];
      end
      rd16(1, v1);
      chk("R5 edge count", v1, v);
    end
    cnt_pin_i = '0;
    wr(1, 8'h00);

    // R9 split mode
    wr(0, 8'h13); wr(2, 8'hFE); wr(3, 8'hFD); wr(4, 8'hFF); wr(5, 8'hFF);
    wr(1, 8'h50);
    lo0 = 'hFE; hi0 = 'hFD; v = 16'hFFFF; f = 0; f1 = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1);
      lo0++; if (lo0 == 256) begin lo0 = 0; f = 1; end
      hi0++; if (hi0 == 256) begin hi0 = 0; f1 = 1; end
      v = v + 1'b1;
      rd(2, d); chk("R9 low half", d, lo0);
      rd(3, d); chk("R9 high half", d, hi0);
      chk("R9 flag0", ovf_o[0], f);
      chk("R9 flag1 from high half only", ovf_o[1], f1);
      rd16(1, v1); chk("R9 timer1 runs", v1, v);
    end
    wr(1, 8'h40);
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1);
      hi0 = (hi0 + 1) & 255;
      rd(2, d); chk("R9 low half stopped", d, lo0);
      rd(3, d); chk("R9 high half under run1", d, hi0);
    end
    wr(1, 8'h00);

    // R10 timer 1 frozen in mode 11
    wr(0, 8'h30); wr(4, 8'h34); wr(5, 8'h12); wr(1, 8'h40);
    for (int k = 0; k < 6; k++) cyc(1'b1);
    rd16(1, v1); chk("R10 timer1 holds", v1, 16'h1234);
    chk("R10 no flag1", ovf_o[1], 0);

    summary();
  end
endmodule